// File: doc/BRIEF.md
# Asymmetric Sleep-Line Debouncer

This block cleans up an active-low sleep-state line for a power sequencer. The sequencer sends an evaluation strobe. The block reads the raw line only on that strobe and keeps one debounced verdict: the line is either asserted (sleep requested) or deasserted. The two directions are filtered differently.

Leaving the asserted state needs the line to stay high for a continuous span of millisecond ticks. The span is measured as a modulo-2^TICK_W difference between the free-running tick count and a timestamp taken at the last low sample. Returning to the asserted state needs a set number of consecutive low samples, counted in the same field that otherwise holds the timestamp.

The whole state is one register of TICK_W+1 bits. The top bit is the verdict and the low bits are either the timestamp or the low-sample count. A re-arm input lets the sequencer restart filtering from the asserted state at any time, for example when it starts to watch the line. No data flows through the block, so every pin is a plain control or status pin with no handshake.

Top module: `sleep_debounce`

## Requirements
- R1: During and after reset, `asserted_o` is 1 and the stored timestamp is 0.
- R2: `rearm_i` high at a clock edge makes `asserted_o` 1 after that edge and stores `tick_i` as the timestamp. This takes priority over the strobe and over every other rule.
- R3: While asserted, a strobe that sees `sleep_ni` low keeps `asserted_o` at 1 and replaces the timestamp with the current `tick_i`.
- R4: While asserted, a strobe that sees `sleep_ni` high clears `asserted_o` when (`tick_i` − timestamp) mod 2^TICK_W ≥ SPAN_TICKS (default 2). Otherwise the state is unchanged. On release, the count field becomes 0.
- R5: The difference in R4 wraps modulo 128 by default. A timestamp of 126 with a tick of 0 gives 2, and a tick of 127 gives 1.
- R6: While deasserted, a strobe that sees `sleep_ni` high keeps `asserted_o` at 0 and resets the low-sample count to 0.
- R7: While deasserted, each strobe that sees `sleep_ni` low adds one to the count. The strobe that makes the count reach LOW_SAMPLES (default 2) sets `asserted_o` to 1 and stores that strobe's `tick_i` as the timestamp.
- R8: With `eval_i` low and `rearm_i` low, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Evaluation strobe from the sequencer |
| sleep_ni | input | 1 | Raw active-low sleep line, already synchronised |
| tick_i | input | TICK_W | Free-running millisecond tick count |
| rearm_i | input | 1 | Restart filtering in the asserted state |
| asserted_o | output | 1 | Debounced verdict, 1 = sleep asserted |

## Verification
The hardest case to reach is a release where the span is measured across the wrap of the tick count, with the timestamp just below 2^TICK_W and the tick just past zero. Random tick steps reach it only rarely, so directed sequences place a low sample at tick 126 and then strobe high at ticks 127 and 0. A second hard case is an interrupted return to asserted, where a single high sample falls between low samples. The random stimulus biases the line toward short low bursts so that partial counts happen often. A directed low-high-low pattern covers this case as well.

// File: rtl/sleep_debounce_pkg.sv
package sleep_debounce_pkg;
  // Action chosen for the state register at one edge
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,  // keep state
    ACT_STAMP  = 2'd1,  // asserted, low field <= tick
    ACT_SET_HI = 2'd2,  // deasserted, low field <= 0
    ACT_COUNT  = 2'd3   // deasserted, low field <= low field + 1
  } sdb_act_e;
endpackage

// File: rtl/sdb_span_check.sv
module sdb_span_check #(
  parameter int TICK_W     = 7,
  parameter int SPAN_TICKS = 2
) (
  input  logic [TICK_W-1:0] tick_i,
  input  logic [TICK_W-1:0] stamp_i,
  output logic              span_met_o
);
  localparam logic [TICK_W-1:0] SPAN_V = SPAN_TICKS[TICK_W-1:0];

  logic [TICK_W-1:0] elapsed;

  // modulo 2^TICK_W difference, wraps naturally
  always_comb begin
    elapsed    = tick_i - stamp_i;
    span_met_o = (elapsed >= SPAN_V);
  end
endmodule

// File: rtl/sdb_low_counter.sv
module sdb_low_counter #(
  parameter int TICK_W      = 7,
  parameter int LOW_SAMPLES = 2
) (
  input  logic [TICK_W-1:0] count_i,
  output logic [TICK_W-1:0] count_next_o,
  output logic              reached_o
);
  localparam logic [TICK_W-1:0] LIMIT_V = LOW_SAMPLES[TICK_W-1:0];

  always_comb begin
    count_next_o = count_i + 1'b1;
    reached_o    = (count_next_o >= LIMIT_V);
  end
endmodule

// File: rtl/sdb_decide.sv
module sdb_decide
  import sleep_debounce_pkg::*;
(
  input  logic     rearm_i,
  input  logic     eval_i,
  input  logic     sleep_ni,
  input  logic     deasserted_i,
  input  logic     span_met_i,
  input  logic     reached_i,
  output sdb_act_e act_o
);
  always_comb begin
    act_o = ACT_HOLD;
    if (rearm_i) begin
      act_o = ACT_STAMP;
    end else if (eval_i) begin
      if (!deasserted_i) begin
        if (!sleep_ni)       act_o = ACT_STAMP;
        else if (span_met_i) act_o = ACT_SET_HI;
        else                 act_o = ACT_HOLD;
      end else begin
        if (sleep_ni)        act_o = ACT_SET_HI;
        else if (reached_i)  act_o = ACT_STAMP;
        else                 act_o = ACT_COUNT;
      end
    end
  end
endmodule

// File: rtl/sleep_debounce.sv
module sleep_debounce
  import sleep_debounce_pkg::*;
#(
  parameter int TICK_W      = 7,
  parameter int SPAN_TICKS  = 2,  // must exceed 1
  parameter int LOW_SAMPLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic              sleep_ni,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              rearm_i,
  output logic              asserted_o
);
  localparam logic [TICK_W-1:0] LIMIT_V = LOW_SAMPLES[TICK_W-1:0];

  logic              st_hi_q;   // 1 = deasserted
  logic [TICK_W-1:0] st_low_q;  // timestamp or low-sample count
  logic              span_met;
  logic              reached;
  logic [TICK_W-1:0] count_next;
  sdb_act_e          act;

  sdb_span_check #(.TICK_W(TICK_W), .SPAN_TICKS(SPAN_TICKS)) span_i (
    .tick_i     (tick_i),
    .stamp_i    (st_low_q),
    .span_met_o (span_met)
  );

  sdb_low_counter #(.TICK_W(TICK_W), .LOW_SAMPLES(LOW_SAMPLES)) cnt_i (
    .count_i      (st_low_q),
    .count_next_o (count_next),
    .reached_o    (reached)
  );

  sdb_decide dec_i (
    .rearm_i      (rearm_i),
    .eval_i       (eval_i),
    .sleep_ni     (sleep_ni),
    .deasserted_i (st_hi_q),
    .span_met_i   (span_met),
    .reached_i    (reached),
    .act_o        (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_hi_q  <= 1'b0;
      st_low_q <= '0;
    end else begin
      case (act)
        ACT_STAMP: begin
          st_hi_q  <= 1'b0;
          st_low_q <= tick_i;
        end
        ACT_SET_HI: begin
          st_hi_q  <= 1'b1;
          st_low_q <= '0;
        end
        ACT_COUNT: st_low_q <= count_next;
        default: ;
      endcase
    end
  end

  assign asserted_o = ~st_hi_q;

  AST_REARM_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (asserted_o && st_low_q == $past(tick_i))); // R2
  AST_LOW_KEEPS_ASSERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && !sleep_ni && asserted_o) |=> asserted_o); // R3
  AST_RELEASE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asserted_o) |-> $past(eval_i && sleep_ni && !rearm_i)); // R4
  AST_HIGH_KEEPS_DEASSERTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && sleep_ni && !rearm_i && !asserted_o) |=> (!asserted_o && st_low_q == '0)); // R6
  AST_REASSERT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asserted_o) |-> $past(rearm_i || (eval_i && !sleep_ni))); // R7
  AST_COUNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !asserted_o |-> (st_low_q < LIMIT_V)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eval_i && !rearm_i) |=> ($stable(st_hi_q) && $stable(st_low_q))); // R8
endmodule

// File: tb/sleep_debounce_tb.sv
module sleep_debounce_tb_top;
  localparam int TW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eval = 1'b0;
  logic          sleep_n = 1'b1;
  logic [TW-1:0] tick = '0;
  logic          rearm = 1'b0;
  logic          asserted;

  int n_checks = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_hi = 1'b0;
  logic [TW-1:0] m_low = '0;

  always #2 clk = ~clk;  // 250 MHz

  sleep_debounce dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .eval_i     (eval),
    .sleep_ni   (sleep_n),
    .tick_i     (tick),
    .rearm_i    (rearm),
    .asserted_o (asserted)
  );

  function automatic string model_step(bit ev, bit sl, logic [TW-1:0] tk, bit rm);
    logic [TW-1:0] d;
    if (rm) begin m_hi = 0; m_low = tk; return "R2"; end
    if (!ev) return "R8";
    if (!m_hi) begin
      if (!sl) begin m_low = tk; return "R3"; end
      d = tk - m_low;
      if (d >= 7'd2) begin
        m_hi = 1; m_low = '0;
        return (tk < m_low) ? "R5" : "R4";
      end
      return "R4";
    end else begin
      if (sl) begin m_low = '0; return "R6"; end
      if (m_low + 7'd1 >= 7'd2) begin m_hi = 0; m_low = tk; end
      else m_low = m_low + 7'd1;
      return "R7";
    end
  endfunction

  task automatic check(bit got, bit exp, string req);
    n_checks++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s asserted_o got=%0b expected=%0b", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check at next negedge
  task automatic step(bit ev, bit sl, logic [TW-1:0] tk, bit rm);
    string req;
    eval = ev; sleep_n = sl; tick = tk; rearm = rm;
    req = model_step(ev, sl, tk, rm);
    @(negedge clk);
    check(asserted, !m_hi, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [TW-1:0] t;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(asserted, 1'b1, "R1");  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(asserted, 1'b1, "R1");
    // R1: stamp 0 -> high at tick 1 holds, at tick 2 releases
    step(1, 1, 7'd1, 0);
    check(asserted, 1'b1, "R1");
    step(1, 1, 7'd2, 0);
    check(asserted, 1'b0, "R4");
    // R8: idle keeps deasserted, even with low line
    step(0, 0, 7'd3, 0);
    check(asserted, 1'b0, "R8");
    // R6 then R7 interrupted: low, high, low stays deasserted
    step(1, 0, 7'd4, 0);
    step(1, 1, 7'd5, 0);
    step(1, 0, 7'd6, 0);
    check(asserted, 1'b0, "R6");
    step(1, 0, 7'd7, 0);
    check(asserted, 1'b1, "R7");
    // R7 stamp = 7: high at 8 holds, at 9 releases
    step(1, 1, 7'd8, 0);
    check(asserted, 1'b1, "R7");
    step(1, 1, 7'd9, 0);
    check(asserted, 1'b0, "R7");
    // R2: rearm without strobe, stamp 120
    step(0, 1, 7'd120, 1);
    check(asserted, 1'b1, "R2");
    step(1, 1, 7'd121, 0);
    check(asserted, 1'b1, "R2");
    // R3: low at 126 refreshes stamp; wrap per R5
    step(1, 0, 7'd126, 0);
    step(1, 1, 7'd127, 0);
    check(asserted, 1'b1, "R5");
    step(1, 1, 7'd0, 0);
    check(asserted, 1'b0, "R5");
    // R2 priority over strobe with deasserted high line
    step(1, 1, 7'd10, 1);
    check(asserted, 1'b1, "R2");
    // random phase
    t = 7'd10;
    for (int i = 0; i < 4000; i++) begin
      t = t + 7'($urandom_range(0, 2));
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0), t,
           ($urandom_range(0, 60) == 0));
    end
    finish_run();
  end
endmodule